// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by reading translation entries out of memory. A lookup request carries the linear address, a write flag and a user-mode flag. The walker reads the directory entry at an address built from a directory frame register and the top index field of the linear address. It then reads the table entry that the directory entry points to, and answers with either the physical address and its effective attributes or a fault. The fault carries the faulting address and a three-bit reason code. A directory entry can also map a 4 MiB region directly, and then the walk stops after one read. If paging is turned off, the walker returns the linear address unchanged and touches no memory.

The entry that supplies the frame (the leaf) gets its accessed flag set in memory on a successful use. A small-page leaf also gets its dirty flag set on a successful write. Each update is one write on the same memory port, issued only when the flag is not yet set. The memory port is a plain request/acknowledge interface: the request and address stay stable until the acknowledge, and read data arrives together with the acknowledge. The block handles one lookup at a time.

Top module: `pt_walker`

## Requirements
- R1: When cfg_pg_en is low at acceptance, the response gives rsp_paddr equal to the request address, rsp_attr = 6'b000011, no fault, and no memory access.
- R2: The first read uses address {cfg_dir_frame, vaddr[31:22], 2'b00}.
- R3: For a present directory entry with bit 7 clear, the second read uses {pde[31:12], vaddr[21:12], 2'b00}, and a successful result is rsp_paddr = {pte[31:12], vaddr[11:0]} with rsp_attr[5] = 0.
- R4: A present directory entry with bit 7 set ends the walk after one read, with rsp_paddr = {pde[31:22], vaddr[21:0]} and rsp_attr[5] = 1.
- R5: An entry with bit 0 (present) clear at either level gives rsp_fault = 1, fault_addr = the request address, and fault_code = {user, write, 1'b0}.
- R6: A write request faults with fault_code = {user, 1'b1, 1'b1} when bit 1 (writable) is clear in the leaf, or in the directory entry of a two-level walk.
- R7: A user request faults with fault_code = {1'b1, write, 1'b1} when bit 2 (user) is clear in the leaf, or in the directory entry of a two-level walk.
- R8: After a successful walk, the leaf is written back with bit 5 (accessed) set, and for a small-page write also bit 6 (dirty) set, at the address it was read from. No write happens when those bits were already set or when the walk faults.
- R9: req_ready is high only while idle. rsp_valid is a one-cycle pulse. mem_req, mem_we and mem_addr stay stable until mem_ack.
- R10: rsp_attr bits 0 and 1 are writable and user permission, taken as the AND of both levels for a small page and from the directory entry for a large page. Bits 2, 3 and 4 copy leaf bits 3 (write-through), 4 (cache disable) and 8 (global).
- R11: After reset, req_ready is 1 and rsp_valid and mem_req are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_pg_en | input | 1 | Translation enable |
| cfg_dir_frame | input | 20 | Frame number of the directory |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from user mode |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 1 | Lookup faulted |
| rsp_paddr | output | 32 | Physical address (zero on fault) |
| rsp_attr | output | 6 | {large, global, cache-disable, write-through, user, writable} |
| fault_addr | output | 32 | Faulting linear address |
| fault_code | output | 3 | {user, write, protection(1)/not-present(0)} |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Entry byte address |
| mem_wdata | output | 32 | Updated entry |
| mem_ack | input | 1 | Access complete, read data valid |
| mem_rdata | input | 32 | Entry read data |

## Verification
The bench builds the walker with its default 10/10/12 split, so the directory and table locations it computes are the real ones. The sweep covers all 2048 combinations of the directory flags (present, writable, user, large) and the table flags (present, writable, user, accessed, dirty), each under write and user access. This reaches every fault ordering, every combination of the two permission levels, and every write-back case. The directory frame, the table frame, both index fields and the offset change from case to case, so any wrong address composition shows up.

// File: rtl/pw_pkg.sv
// Shared definitions for the page table walker: walk states and the
// fixed bit positions inside a translation entry and the result attributes.
package pw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_DIR,
        ST_RD_TBL,
        ST_WB,
        ST_DONE
    } walk_st_e;

    // Entry flag positions (layout decoded by the walker)
    localparam int E_PRESENT = 0;
    localparam int E_WRITE   = 1;
    localparam int E_USER    = 2;
    localparam int E_WT      = 3;
    localparam int E_CD      = 4;
    localparam int E_ACC     = 5;
    localparam int E_DIRTY   = 6;
    localparam int E_LARGE   = 7;
    localparam int E_GLOBAL  = 8;

    localparam int ATTR_W = 6;
endpackage

// File: rtl/pw_addr_gen.sv
// Address composition for the walker. Builds the directory and table entry
// byte addresses and the physical result for small and large pages.
// Assumes 4-byte entries and frames aligned to 2**OFF_W bytes.
module pw_addr_gen #(
    parameter int DIR_IDX_W = 10,
    parameter int TBL_IDX_W = 10,
    parameter int OFF_W     = 12,
    localparam int VA_W     = DIR_IDX_W + TBL_IDX_W + OFF_W,
    localparam int FRAME_W  = VA_W - OFF_W
) (
    input  logic [FRAME_W-1:0] dir_frame,
    input  logic [VA_W-1:0]    vaddr,
    input  logic [FRAME_W-1:0] tbl_frame,
    input  logic [FRAME_W-1:0] leaf_frame,
    output logic [VA_W-1:0]    dir_ent_addr,
    output logic [VA_W-1:0]    tbl_ent_addr,
    output logic [VA_W-1:0]    pa_small,
    output logic [VA_W-1:0]    pa_large
);
    localparam int ENT_SH   = 2;
    localparam int LG_OFF_W = TBL_IDX_W + OFF_W;

    // Entry addresses: frame base plus scaled index
    always_comb begin
        dir_ent_addr = {dir_frame, OFF_W'(0)}
                     | (VA_W'(vaddr[VA_W-1 -: DIR_IDX_W]) << ENT_SH);
        tbl_ent_addr = {tbl_frame, OFF_W'(0)}
                     | (VA_W'(vaddr[OFF_W +: TBL_IDX_W]) << ENT_SH);
    end

    // Physical results for both page sizes
    always_comb begin
        pa_small = {leaf_frame, vaddr[OFF_W-1:0]};
        pa_large = {leaf_frame[FRAME_W-1:TBL_IDX_W], vaddr[LG_OFF_W-1:0]};
    end
endmodule

// File: rtl/pw_perm_eval.sv
// Permission evaluation. Combines the writable and user flags of one or
// two levels and flags a protection fault for the access kind.
module pw_perm_eval (
    input  logic up_rw,
    input  logic up_us,
    input  logic lo_rw,
    input  logic lo_us,
    input  logic two_level,
    input  logic is_write,
    input  logic is_user,
    output logic eff_rw,
    output logic eff_us,
    output logic prot_fault
);
    // Effective rights and fault decision
    always_comb begin
        eff_rw     = up_rw & (two_level ? lo_rw : 1'b1);
        eff_us     = up_us & (two_level ? lo_us : 1'b1);
        prot_fault = (is_write & ~eff_rw) | (is_user & ~eff_us);
    end
endmodule

// File: rtl/pw_leaf_update.sv
// Accessed/dirty update of a leaf entry. Computes the entry to write back
// and whether a write is needed at all. Dirty is only set when allowed.
module pw_leaf_update #(
    parameter int ENT_W = 32
) (
    input  logic [ENT_W-1:0] entry,
    input  logic             is_write,
    input  logic             dirty_en,
    output logic [ENT_W-1:0] new_entry,
    output logic             need_wb
);
    import pw_pkg::*;

    // Set flags and compare with the original
    always_comb begin
        new_entry           = entry;
        new_entry[E_ACC]    = 1'b1;
        if (is_write && dirty_en) begin
            new_entry[E_DIRTY] = 1'b1;
        end
        need_wb = (new_entry != entry);
    end
endmodule

// File: rtl/pt_walker.sv
// Two-level page table walker. Accepts one lookup at a time, reads the
// directory entry and, for small pages, the table entry over a
// request/acknowledge memory port. It answers with the physical address
// or a fault, and writes back accessed/dirty flags of the leaf when needed.
// Assumes cfg inputs are stable from acceptance until the response.
module pt_walker #(
    parameter int DIR_IDX_W = 10,
    parameter int TBL_IDX_W = 10,
    parameter int OFF_W     = 12,
    localparam int VA_W     = DIR_IDX_W + TBL_IDX_W + OFF_W,
    localparam int FRAME_W  = VA_W - OFF_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_pg_en,
    input  logic [FRAME_W-1:0]         cfg_dir_frame,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [VA_W-1:0]            req_vaddr,
    input  logic                       req_write,
    input  logic                       req_user,
    output logic                       rsp_valid,
    output logic                       rsp_fault,
    output logic [VA_W-1:0]            rsp_paddr,
    output logic [pw_pkg::ATTR_W-1:0]  rsp_attr,
    output logic [VA_W-1:0]            fault_addr,
    output logic [2:0]                 fault_code,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [VA_W-1:0]            mem_addr,
    output logic [VA_W-1:0]            mem_wdata,
    input  logic                       mem_ack,
    input  logic [VA_W-1:0]            mem_rdata
);
    import pw_pkg::*;

    walk_st_e           state;
    logic [VA_W-1:0]    va_q;
    logic               wr_q, us_q;
    logic [FRAME_W-1:0] dir_frame_q, pde_frame_q;
    logic               pde_rw_q, pde_us_q;
    logic [VA_W-1:0]    wb_addr_q, wb_data_q, paddr_q;
    logic [ATTR_W-1:0]  attr_q;
    logic               fault_q;
    logic [2:0]         code_q;

    logic [VA_W-1:0]    dir_ent_addr, tbl_ent_addr, pa_small, pa_large;
    logic [VA_W-1:0]    leaf_addr, new_entry;
    logic               in_tbl, eff_rw, eff_us, prot_fault, need_wb;

    assign in_tbl = (state == ST_RD_TBL);

    pw_addr_gen #(
        .DIR_IDX_W (DIR_IDX_W),
        .TBL_IDX_W (TBL_IDX_W),
        .OFF_W     (OFF_W)
    ) u_addr (
        .dir_frame    (dir_frame_q),
        .vaddr        (va_q),
        .tbl_frame    (pde_frame_q),
        .leaf_frame   (mem_rdata[VA_W-1:OFF_W]),
        .dir_ent_addr (dir_ent_addr),
        .tbl_ent_addr (tbl_ent_addr),
        .pa_small     (pa_small),
        .pa_large     (pa_large)
    );

    pw_perm_eval u_perm (
        .up_rw      (in_tbl ? pde_rw_q : mem_rdata[E_WRITE]),
        .up_us      (in_tbl ? pde_us_q : mem_rdata[E_USER]),
        .lo_rw      (mem_rdata[E_WRITE]),
        .lo_us      (mem_rdata[E_USER]),
        .two_level  (in_tbl),
        .is_write   (wr_q),
        .is_user    (us_q),
        .eff_rw     (eff_rw),
        .eff_us     (eff_us),
        .prot_fault (prot_fault)
    );

    pw_leaf_update #(
        .ENT_W (VA_W)
    ) u_leaf (
        .entry     (mem_rdata),
        .is_write  (wr_q),
        .dirty_en  (in_tbl),
        .new_entry (new_entry),
        .need_wb   (need_wb)
    );

    assign leaf_addr = in_tbl ? tbl_ent_addr : dir_ent_addr;

    // Walk sequencing and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            va_q        <= '0;
            wr_q        <= 1'b0;
            us_q        <= 1'b0;
            dir_frame_q <= '0;
            pde_frame_q <= '0;
            pde_rw_q    <= 1'b0;
            pde_us_q    <= 1'b0;
            wb_addr_q   <= '0;
            wb_data_q   <= '0;
            paddr_q     <= '0;
            attr_q      <= '0;
            fault_q     <= 1'b0;
            code_q      <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q        <= req_vaddr;
                        wr_q        <= req_write;
                        us_q        <= req_user;
                        dir_frame_q <= cfg_dir_frame;
                        fault_q     <= 1'b0;
                        code_q      <= '0;
                        if (cfg_pg_en) begin
                            state <= ST_RD_DIR;
                        end else begin
                            paddr_q <= req_vaddr;
                            attr_q  <= ATTR_W'(3);
                            state   <= ST_DONE;
                        end
                    end
                end
                ST_RD_DIR, ST_RD_TBL: begin
                    if (mem_ack) begin
                        if (!mem_rdata[E_PRESENT] || (!in_tbl && mem_rdata[E_LARGE] && prot_fault)
                            || (in_tbl && prot_fault)) begin
                            fault_q <= 1'b1;
                            code_q  <= {us_q, wr_q, mem_rdata[E_PRESENT]};
                            paddr_q <= '0;
                            attr_q  <= '0;
                            state   <= ST_DONE;
                        end else if (!in_tbl && !mem_rdata[E_LARGE]) begin
                            pde_frame_q <= mem_rdata[VA_W-1:OFF_W];
                            pde_rw_q    <= mem_rdata[E_WRITE];
                            pde_us_q    <= mem_rdata[E_USER];
                            state       <= ST_RD_TBL;
                        end else begin
                            paddr_q   <= in_tbl ? pa_small : pa_large;
                            attr_q    <= {~in_tbl, mem_rdata[E_GLOBAL], mem_rdata[E_CD],
                                          mem_rdata[E_WT], eff_us, eff_rw};
                            wb_addr_q <= leaf_addr;
                            wb_data_q <= new_entry;
                            state     <= need_wb ? ST_WB : ST_DONE;
                        end
                    end
                end
                ST_WB: begin
                    if (mem_ack) begin
                        state <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port drive from state and registers
    always_comb begin
        req_ready  = (state == ST_IDLE);
        rsp_valid  = (state == ST_DONE);
        rsp_fault  = (state == ST_DONE) && fault_q;
        rsp_paddr  = paddr_q;
        rsp_attr   = attr_q;
        fault_addr = va_q;
        fault_code = code_q;
        mem_req    = (state == ST_RD_DIR) || (state == ST_RD_TBL) || (state == ST_WB);
        mem_we     = (state == ST_WB);
        mem_wdata  = wb_data_q;
        case (state)
            ST_RD_DIR: mem_addr = dir_ent_addr;
            ST_RD_TBL: mem_addr = tbl_ent_addr;
            default:   mem_addr = wb_addr_q;
        endcase
    end
endmodule

// File: rtl/pt_walker_chk.sv
// Protocol checker for the walker, attached through bind.
module pt_walker_chk #(
    parameter int VA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic            rsp_fault,
    input logic            mem_req,
    input logic            mem_we,
    input logic            mem_ack,
    input logic [VA_W-1:0] mem_addr,
    input logic [VA_W-1:0] mem_wdata
);
    // R9
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R9
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R8
    wb_sets_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[5]);

    // R5
    fault_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_valid);

    // R9
    quiet_at_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!mem_req && !req_ready));
endmodule

bind pt_walker pt_walker_chk #(.VA_W(VA_W)) u_chk (.*);

// File: tb/pt_walker_bench.sv
// Self-checking bench: behavioural entry memory plus a sweep over flag
// combinations with expected results computed from the requirements.
module pt_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_pg_en = 1'b0;
    logic [19:0] cfg_dir_frame = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        rsp_valid, rsp_fault;
    logic [31:0] rsp_paddr, fault_addr;
    logic [5:0]  rsp_attr;
    logic [2:0]  fault_code;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    logic [31:0] mem [0:4095];
    logic        tb_wr = 1'b0;
    logic [31:0] tb_wr_addr = '0, tb_wr_data = '0;
    int          rd_cnt = 0, wb_cnt = 0;
    logic [31:0] last_rd = '0, prev_rd = '0, last_wb_addr = '0, last_wb_data = '0;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pt_walker u_pt_walker (.*);

    // Behavioural memory with one-cycle acknowledge
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else begin
            if (tb_wr) mem[tb_wr_addr[13:2]] <= tb_wr_data;
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr[13:2]] <= mem_wdata;
                    wb_cnt       <= wb_cnt + 1;
                    last_wb_addr <= mem_addr;
                    last_wb_data <= mem_wdata;
                end else begin
                    mem_rdata <= mem[mem_addr[13:2]];
                    rd_cnt    <= rd_cnt + 1;
                    prev_rd   <= last_rd;
                    last_rd   <= mem_addr;
                end
            end else begin
                mem_ack <= 1'b0;
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic poke(logic [31:0] a, logic [31:0] d);
        @(negedge clk);
        tb_wr = 1'b1; tb_wr_addr = a; tb_wr_data = d;
        @(negedge clk);
        tb_wr = 1'b0;
    endtask

    task automatic walk(logic [31:0] va, logic w, logic u);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = w; req_user = u;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!rsp_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
        if (!rsp_valid) begin
            fails++; checks++;
            $display("FAIL R9 no response actual=0 expected=1");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL R9 watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 ready", 32'(req_ready), 1);
        chk("R11 rsp_valid", 32'(rsp_valid), 0);
        chk("R11 mem_req", 32'(mem_req), 0);
        rst_n = 1'b1;

        // R1 paging disabled: identity, no memory use
        for (int i = 0; i < 8; i++) begin
            int r0;
            logic [31:0] va;
            va = 32'h9E37_79B9 * (i + 1);
            r0 = rd_cnt + wb_cnt;
            walk(va, i[0], i[1]);
            chk("R1 paddr", rsp_paddr, va);
            chk("R1 attr", 32'(rsp_attr), 32'h3);
            chk("R1 fault", 32'(rsp_fault), 0);
            chk("R1 no mem", 32'(rd_cnt + wb_cnt - r0), 0);
        end

        cfg_pg_en = 1'b1;
        for (int k = 0; k < 2048; k++) begin
            logic [9:0]  di, ti;
            logic [11:0] off;
            logic [31:0] va, pde, pte, da, ta, exp_pa, exp_new, leaf, la;
            logic        p1, rw1, us1, ps, p2, rw2, us2, a2, d2, w, u, g, wt, cd;
            logic        fault, present, ew, eu, big;
            int          r0, w0, exp_rd;
            p1 = k[0]; rw1 = k[1]; us1 = k[2]; ps = k[3];
            p2 = k[4]; rw2 = k[5]; us2 = k[6]; a2 = k[7]; d2 = k[8];
            w = k[9]; u = k[10];
            wt = k[0] ^ k[6]; cd = k[2] ^ k[7]; g = k[5] ^ k[9];
            di  = 10'((k * 37 + 5) % 1024);
            ti  = 10'((k * 53 + 11) % 1024);
            off = 12'((k * 97) % 4096);
            va  = {di, ti, off};
            cfg_dir_frame = {19'd0, k[1]};
            pde = {10'(di ^ 10'h155), 10'(k[0] ? 2 : 3), 3'b000, g, ps, 1'b0,
                   a2, cd, wt, us1, rw1, p1};
            pte = {20'((k * 3 + 7) ^ 20'hABCDE), 3'b000, g, 1'b0, d2, a2, cd, wt, us2, rw2, p2};
            da  = {19'd0, k[1], di, 2'b00};
            ta  = {pde[31:12], ti, 2'b00};
            poke(da, pde);
            poke(ta, pte);

            // expected result from the requirements
            big = ps;
            fault = 1'b0; present = 1'b1; exp_rd = 1;
            leaf = pde; la = da; ew = rw1; eu = us1;
            exp_pa = {pde[31:22], va[21:0]};
            if (!p1) begin
                fault = 1'b1; present = 1'b0;
            end else if (!ps) begin
                exp_rd = 2; leaf = pte; la = ta;
                ew = rw1 & rw2; eu = us1 & us2;
                exp_pa = {pte[31:12], off};
                if (!p2) begin
                    fault = 1'b1; present = 1'b0;
                end
            end
            if (!fault && ((w && !ew) || (u && !eu))) fault = 1'b1;
            exp_new = leaf | 32'h20 | ((w && !big) ? 32'h40 : 32'h0);

            r0 = rd_cnt; w0 = wb_cnt;
            walk(va, w, u);
            chk("R2 dir addr", (exp_rd == 2) ? prev_rd : last_rd, da);
            chk("R9 read count", 32'(rd_cnt - r0), 32'(exp_rd));
            if (exp_rd == 2) chk("R3 tbl addr", last_rd, ta);
            if (fault) begin
                chk(!present ? "R5 fault" : (w && !ew) ? "R6 fault" : "R7 fault",
                    32'(rsp_fault), 1);
                chk(!present ? "R5 code" : (w && !ew) ? "R6 code" : "R7 code",
                    32'(fault_code), 32'({u, w, present}));
                chk("R5 fault_addr", fault_addr, va);
                chk("R8 no wb on fault", 32'(wb_cnt - w0), 0);
            end else begin
                chk(big ? "R4 fault" : "R3 fault", 32'(rsp_fault), 0);
                chk(big ? "R4 paddr" : "R3 paddr", rsp_paddr, exp_pa);
                chk("R10 attr", 32'(rsp_attr), 32'({big, g, cd, wt, eu, ew}));
                if (exp_new != leaf) begin
                    chk("R8 wb count", 32'(wb_cnt - w0), 1);
                    chk("R8 wb addr", last_wb_addr, la);
                    chk("R8 wb data", last_wb_data, exp_new);
                    chk("R8 memory", mem[la[13:2]], exp_new);
                end else begin
                    chk("R8 no wb when set", 32'(wb_cnt - w0), 0);
                end
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule